// File: doc/BRIEF.md
# Maskable Interrupt Priority Arbiter

This block gathers interrupt events from a set of peripheral sources and decides which one, if any, the processor should take. Each source owns a small control register. The register holds a pending request bit and a 3-bit level, where level 0 turns the source off and 7 is the most urgent. The processor supplies its current interrupt priority level (IPL) on an input. A single global enable flag, which software can write, gates every source.

In every cycle the arbiter takes the pending sources that are enabled and whose level is strictly above the IPL. It picks the most urgent of them, and on a tie the lowest source index wins. It presents the winner on an accept strobe together with the source index and level. The winner's pending bit clears on the following clock edge, so each event is accepted once.

Software writes through a simple write port. It can reprogram a source's level and clear its pending bit. It can never create a request. After accepting, the processor raises its IPL on its own side.

Top module: `irq_prio_arb`

## Requirements
- R1: After reset the enable flag, all pending bits and all levels are 0, and `acc_valid` is 0.
- R2: `irq_in[i]` high during a cycle sets the pending bit of source i at that cycle's closing clock edge.
- R3: A source is eligible only if the enable flag is 1, its pending bit is 1 and its level is strictly greater than `ipl`. So `ipl` = 7 blocks every source and level 0 is never eligible.
- R4: Among eligible sources, the one with the highest level wins. Between equal levels, the lowest index wins.
- R5: `acc_valid`, `acc_idx` and `acc_lvl` show the winner in the same cycle the state makes it eligible. The winner's pending bit clears at the next edge, so the strobe lasts one cycle unless a new event arrives.
- R6: A write to `wr_addr` = i (i < NUM_SRC) loads the level from `wr_data[2:0]`. `wr_data[3]` = 0 clears the pending bit of source i. `wr_data[3]` = 1 leaves the pending bit unchanged and never sets it.
- R7: When a hardware event on source i arrives in the same cycle as a software clear or an acceptance of source i, the pending bit ends up set.
- R8: A write to `wr_addr` = NUM_SRC loads the enable flag from `wr_data[0]`. Any write changes only the storage it addresses: other sources' levels and pending bits, and the enable flag, are untouched.
- R9: `ipl` is not registered. A change on `ipl` changes eligibility and the accept outputs within the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_in | input | NUM_SRC | Per-source event, one bit per source |
| ipl | input | 3 | Processor interrupt priority level |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | $clog2(NUM_SRC+1) | Write address: sources 0..NUM_SRC-1, then the enable flag |
| wr_data | input | 4 | Write data: level in [2:0], keep-pending in [3]; enable in [0] |
| acc_valid | output | 1 | Accept strobe |
| acc_idx | output | $clog2(NUM_SRC) | Index of the accepted source |
| acc_lvl | output | 3 | Level of the accepted source |

## Verification
A wrong pending bit, level or enable flag in this block becomes visible at the accept outputs. The error shows as a missing, extra or misdirected accept as soon as the bench presents an IPL that the stored level can beat, usually in the very cycle after the faulty write or event. For that reason the bench follows every state change with cycles that try to accept. It also sweeps every pairing of IPL and level. A winner bit that fails to clear shows up as a strobe repeated in the next cycle. A write that touches foreign storage shows up as a changed accept order or level.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
    localparam int LVL_W   = 3;
    localparam int REQ_POS = LVL_W;
    localparam int WR_DW   = LVL_W + 1;
    localparam int EN_POS  = 0;

    typedef logic [LVL_W-1:0] lvl_t;

    typedef struct packed {
        logic req;
        lvl_t lvl;
    } src_state_t;

    typedef struct packed {
        logic en;
    } gate_state_t;
endpackage

// File: rtl/irq_src_ctrl.sv
module irq_src_ctrl
    import irq_arb_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hw_set,
    input  logic             wr_sel,
    input  logic [WR_DW-1:0] wr_data,
    input  logic             acc_clr,
    output logic             req,
    output lvl_t             lvl
);
    src_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_sel) begin
            st_d.lvl = wr_data[LVL_W-1:0];
            if (!wr_data[REQ_POS]) begin
                st_d.req = 1'b0;
            end
        end
        if (acc_clr) begin
            st_d.req = 1'b0;
        end
        // hardware event outranks every clear
        if (hw_set) begin
            st_d.req = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign req = st_q.req;
    assign lvl = st_q.lvl;
endmodule

// File: rtl/irq_wr_decode.sv
module irq_wr_decode
    import irq_arb_pkg::*;
#(
    parameter int NUM_SRC = 8,
    parameter int AW      = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [AW-1:0]      wr_addr,
    input  logic               en_bit,
    output logic [NUM_SRC-1:0] src_sel,
    output logic               en_flag
);
    gate_state_t g_d, g_q;
    logic        gate_sel;

    always_comb begin
        for (int i = 0; i < NUM_SRC; i++) begin
            src_sel[i] = wr_en && (wr_addr == AW'(i));
        end
        gate_sel = wr_en && (wr_addr == AW'(NUM_SRC));
        g_d = g_q;
        if (gate_sel) begin
            g_d.en = en_bit;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            g_q <= '0;
        end else begin
            g_q <= g_d;
        end
    end

    assign en_flag = g_q.en;
endmodule

// File: rtl/irq_prio_select.sv
module irq_prio_select
    import irq_arb_pkg::*;
#(
    parameter int NUM_SRC = 8,
    parameter int IW      = 3
) (
    input  logic [NUM_SRC-1:0] req,
    input  lvl_t               lvl [NUM_SRC],
    input  logic               en_flag,
    input  lvl_t               ipl,
    output logic [NUM_SRC-1:0] grant,
    output logic               win_valid,
    output logic [IW-1:0]      win_idx,
    output lvl_t               win_lvl
);
    logic [NUM_SRC-1:0] elig;

    always_comb begin
        win_valid = 1'b0;
        win_idx   = '0;
        win_lvl   = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            elig[i] = en_flag && req[i] && (lvl[i] > ipl);
            // strict compare keeps the lower index on a tie
            if (elig[i] && (!win_valid || (lvl[i] > win_lvl))) begin
                win_valid = 1'b1;
                win_idx   = IW'(i);
                win_lvl   = lvl[i];
            end
        end
        for (int i = 0; i < NUM_SRC; i++) begin
            grant[i] = win_valid && (win_idx == IW'(i));
        end
    end
endmodule

// File: rtl/irq_prio_arb.sv
module irq_prio_arb
    import irq_arb_pkg::*;
#(
    parameter  int NUM_SRC = 8,
    localparam int IW      = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1,
    localparam int AW      = $clog2(NUM_SRC + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] irq_in,
    input  logic [LVL_W-1:0]   ipl,
    input  logic               wr_en,
    input  logic [AW-1:0]      wr_addr,
    input  logic [WR_DW-1:0]   wr_data,
    output logic               acc_valid,
    output logic [IW-1:0]      acc_idx,
    output logic [LVL_W-1:0]   acc_lvl
);
    logic [NUM_SRC-1:0] src_sel;
    logic [NUM_SRC-1:0] req_vec;
    logic [NUM_SRC-1:0] grant;
    lvl_t               src_lvl [NUM_SRC];
    logic               en_flag;

    irq_wr_decode #(
        .NUM_SRC (NUM_SRC),
        .AW      (AW)
    ) u_dec (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .en_bit  (wr_data[EN_POS]),
        .src_sel (src_sel),
        .en_flag (en_flag)
    );

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        irq_src_ctrl u_src (
            .clk     (clk),
            .rst_n   (rst_n),
            .hw_set  (irq_in[g]),
            .wr_sel  (src_sel[g]),
            .wr_data (wr_data),
            .acc_clr (grant[g]),
            .req     (req_vec[g]),
            .lvl     (src_lvl[g])
        );
    end

    irq_prio_select #(
        .NUM_SRC (NUM_SRC),
        .IW      (IW)
    ) u_sel (
        .req       (req_vec),
        .lvl       (src_lvl),
        .en_flag   (en_flag),
        .ipl       (ipl),
        .grant     (grant),
        .win_valid (acc_valid),
        .win_idx   (acc_idx),
        .win_lvl   (acc_lvl)
    );
endmodule

// File: rtl/irq_arb_chk.sv
module irq_arb_chk
    import irq_arb_pkg::*;
#(
    parameter  int NUM_SRC = 8,
    localparam int IW      = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1,
    localparam int AW      = $clog2(NUM_SRC + 1)
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_SRC-1:0] irq_in,
    input logic [LVL_W-1:0]   ipl,
    input logic               wr_en,
    input logic [AW-1:0]      wr_addr,
    input logic               acc_valid,
    input logic [IW-1:0]      acc_idx,
    input logic [LVL_W-1:0]   acc_lvl,
    input logic               en_flag,
    input logic [NUM_SRC-1:0] req
);
    // R3
    accept_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |-> en_flag);

    // R3
    accept_above_ipl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |-> (acc_lvl > ipl));

    // R3
    accept_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |-> req[acc_idx]);

    // R5
    winner_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !irq_in[acc_idx]) |=> !req[$past(acc_idx)]);

    // R6
    sw_never_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (int'(wr_addr) < NUM_SRC) && !req[wr_addr[IW-1:0]]
         && !irq_in[wr_addr[IW-1:0]]) |=> !req[$past(wr_addr[IW-1:0])]);

    for (genvar k = 0; k < NUM_SRC; k++) begin : g_set
        // R7
        hw_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
            irq_in[k] |=> req[k]);
    end
endmodule

bind irq_prio_arb irq_arb_chk #(.NUM_SRC(NUM_SRC)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_in    (irq_in),
    .ipl       (ipl),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .acc_valid (acc_valid),
    .acc_idx   (acc_idx),
    .acc_lvl   (acc_lvl),
    .en_flag   (en_flag),
    .req       (req_vec)
);

// File: tb/tb_irq_prio_arb.sv
`timescale 1ns/1ps
module tb_irq_prio_arb;
    localparam int N  = 8;
    localparam int IW = 3;
    localparam int AW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  irq_in = '0;
    logic [2:0]    ipl = 3'd0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [3:0]    wr_data = '0;
    logic          acc_valid;
    logic [IW-1:0] acc_idx;
    logic [2:0]    acc_lvl;

    irq_prio_arb #(.NUM_SRC(N)) dut (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .ipl(ipl),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .acc_valid(acc_valid), .acc_idx(acc_idx), .acc_lvl(acc_lvl)
    );

    always #2 clk = ~clk;

    typedef struct {
        string    tag;
        logic     v;
        logic [2:0] idx;
        logic [2:0] lvl;
    } exp_t;
    exp_t sb[$];

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    // reference state
    bit       m_req [N];
    bit [2:0] m_lvl [N];
    bit       m_en = 0;
    // inputs and winner of the previous cycle
    bit [N-1:0] p_irq = '0;
    bit         p_we = 0;
    bit [3:0]   p_addr = '0;
    bit [3:0]   p_data = '0;
    bit         p_v = 0;
    bit [2:0]   p_i = '0;

    task automatic cyc(input string tag, input bit [N-1:0] irq, input bit [2:0] l_ipl,
                       input bit we, input bit [3:0] addr, input bit [3:0] data);
        exp_t e;
        @(posedge clk); #1;
        for (int i = 0; i < N; i++) begin
            if (p_v && p_i == 3'(i)) m_req[i] = 0;
            if (p_we && p_addr == 4'(i)) begin
                m_lvl[i] = p_data[2:0];
                if (!p_data[3]) m_req[i] = 0;
            end
            if (p_irq[i]) m_req[i] = 1;
        end
        if (p_we && p_addr == 4'(N)) m_en = p_data[0];
        irq_in = irq; ipl = l_ipl; wr_en = we; wr_addr = addr; wr_data = data;
        e.tag = tag; e.v = 0; e.idx = '0; e.lvl = '0;
        for (int i = 0; i < N; i++) begin
            if (m_en && m_req[i] && (m_lvl[i] > l_ipl) && (!e.v || m_lvl[i] > e.lvl)) begin
                e.v = 1; e.idx = 3'(i); e.lvl = m_lvl[i];
            end
        end
        sb.push_back(e);
        p_irq = irq; p_we = we; p_addr = addr; p_data = data; p_v = e.v; p_i = e.idx;
    endtask

    task automatic wr(input string tag, input bit [3:0] addr, input bit [3:0] data, input bit [2:0] l_ipl);
        cyc(tag, '0, l_ipl, 1'b1, addr, data);
    endtask

    task automatic idle(input string tag, input bit [2:0] l_ipl);
        cyc(tag, '0, l_ipl, 1'b0, '0, '0);
    endtask

    always @(negedge clk) begin
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            n_chk++;
            if (acc_valid !== e.v || (e.v && (acc_idx !== e.idx || acc_lvl !== e.lvl))) begin
                n_fail++;
                $display("FAIL %s: valid=%0b idx=%0d lvl=%0d expected valid=%0b idx=%0d lvl=%0d",
                         e.tag, acc_valid, acc_idx, acc_lvl, e.v, e.idx, e.lvl);
            end
        end
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run did not finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < N; i++) begin m_req[i] = 0; m_lvl[i] = 0; end
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R1 reset state
        idle("R1 reset idle", 3'd0);
        idle("R1 reset idle", 3'd0);

        // R2 / R3 / R8 / R5: event while disabled, then enable
        wr("R6 program src2", 4'd2, 4'b1101, 3'd0);
        cyc("R2 event src2", 8'h04, 3'd0, 1'b0, '0, '0);
        idle("R3 disabled blocks", 3'd0);
        wr("R8 enable write", 4'd8, 4'b0001, 3'd0);
        idle("R5 accept src2", 3'd0);
        idle("R5 strobe single", 3'd0);

        // R9: ipl acts in the same cycle
        cyc("R2 event src2 again", 8'h04, 3'd7, 1'b0, '0, '0);
        idle("R9 ipl equal blocks", 3'd5);
        idle("R9 ipl lowered accepts", 3'd4);

        // R3 sweep of ipl versus level
        for (int ip = 0; ip < 8; ip++) begin
            for (int lv = 0; lv < 8; lv++) begin
                wr("R3 sweep program", 4'd0, {1'b1, 3'(lv)}, 3'd7);
                cyc("R3 sweep event", 8'h01, 3'd7, 1'b0, '0, '0);
                idle("R3 sweep compare", 3'(ip));
                wr("R6 sweep clear", 4'd0, {1'b0, 3'(lv)}, 3'd7);
            end
        end

        // R4 ordering
        wr("R4 program", 4'd1, 4'b1011, 3'd7);
        wr("R4 program", 4'd4, 4'b1110, 3'd7);
        wr("R4 program", 4'd6, 4'b1110, 3'd7);
        wr("R4 program", 4'd7, 4'b1010, 3'd7);
        cyc("R4 events", 8'hD2, 3'd7, 1'b0, '0, '0);
        idle("R4 hold", 3'd7);
        for (int k = 0; k < 5; k++) idle("R4 order", 3'd0);

        // R6 software clear and no set
        wr("R6 program src3", 4'd3, 4'b1100, 3'd7);
        cyc("R2 event src3", 8'h08, 3'd7, 1'b0, '0, '0);
        wr("R6 clear src3", 4'd3, 4'b0100, 3'd7);
        idle("R6 cleared no accept", 3'd0);
        wr("R6 write one", 4'd3, 4'b1100, 3'd0);
        idle("R6 write one no set", 3'd0);

        // R7 event beats clears
        wr("R7 program src5", 4'd5, 4'b1111, 3'd7);
        cyc("R7 event with clear", 8'h20, 3'd7, 1'b1, 4'd5, 4'b0111);
        idle("R7 event kept", 3'd0);
        cyc("R7 second event", 8'h20, 3'd7, 1'b0, '0, '0);
        cyc("R7 event during accept", 8'h20, 3'd0, 1'b0, '0, '0);
        idle("R7 re-accept", 3'd0);
        idle("R7 drained", 3'd0);

        // R8 independence
        wr("R8 disable", 4'd8, 4'b1110, 3'd0);
        cyc("R8 event src1", 8'h02, 3'd0, 1'b0, '0, '0);
        idle("R8 disabled", 3'd0);
        wr("R8 other src write", 4'd2, 4'b1001, 3'd0);
        wr("R8 enable", 4'd8, 4'b0001, 3'd0);
        idle("R8 src1 level intact", 3'd2);
        idle("R8 drained", 3'd0);

        wait (sb.size() == 0);
        @(posedge clk);
        @(negedge clk);
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule